// File: doc/BRIEF.md
# Strap-Sampled Configuration Register Bank

This block holds the handful of configuration values a high-speed link conditioner needs: an edge-boost code, a DC-boost code, a receive-equalization code, and a flag that keeps the link state machine halted. None of these has a fixed reset value. On the first clock edge after reset is released, the block reads a pre-decoded 4-level boost strap and a 3-level equalization strap. It converts each through a fixed translation table and loads the results. The straps are never looked at again until the next reset.

At that same edge the block also records the levels of the two serial-bus lines. Register access is opened to an external serial slave front end only if both lines were high. That front end presents an 8-bit offset, 8-bit write data and a write strobe. It reads back through a combinational read-data port. When access is closed, writes do nothing and reads return zero. The 7-bit slave address the front end must answer to is offered as a constant output.

Top module: `cfg_strap_bank`

## Requirements
- R1: Straps and bus-line levels are captured only at the first rising clock edge after rst_n goes high. Later changes on boost_lvl, eq_lvl, scl_lvl or sda_lvl change no output until reset is asserted and released again.
- R2: host_en is 1 after capture only if scl_lvl and sda_lvl were both 1 at the capture edge. While host_en is 0, acc_wr changes nothing and acc_rdata reads 0x00.
- R3: edge_code takes 0x0, 0x3, 0x6, 0xA for boost_lvl 0, 1, 2, 3. It sits in bits 7:4 of offset 0x01, whose bits 3:0 load the reserved pattern 0x5.
- R4: dc_code takes 0x0, 0x2, 0x2, 0x6 for boost_lvl 0, 1, 2, 3. It sits in bits 3:0 of offset 0x0E, whose bits 7:4 load the reserved pattern 0x9.
- R5: eq_code is the byte at offset 0x25. It loads 0x00, 0x33, 0x66 for eq_lvl 00 (low), 01 (mid), 10 (high); the unused code 11 is taken as mid (0x33).
- R6: cfg_active is bit 0 of offset 0x03. It is 1 after capture; bits 7:1 load the reserved pattern 0x24. Writing the bit clears or sets it.
- R7: With host_en at 1, a write to a defined offset replaces the whole byte, reserved bits included. The new value shows on the code outputs and on reads from the next cycle on.
- R8: Offsets other than 0x01, 0x03, 0x0E and 0x25 read 0x00, and writes to them change no defined register.
- R9: A write present during the capture edge is dropped, and the strap-derived value is kept.
- R10: slv_addr is the constant 7-bit value 0x2C.
- R11: While rst_n is low: edge_code, dc_code and eq_code are 0, cfg_active is 1, host_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release triggers capture |
| boost_lvl | input | 2 | Decoded boost strap level 0..3 |
| eq_lvl | input | 2 | Decoded equalization strap: 00 low, 01 mid, 10 high |
| scl_lvl | input | 1 | Serial clock line level |
| sda_lvl | input | 1 | Serial data line level |
| acc_off | input | 8 | Register offset for read and write |
| acc_wdata | input | 8 | Write data |
| acc_wr | input | 1 | Write strobe, one cycle per write |
| acc_rdata | output | 8 | Read data for acc_off |
| host_en | output | 1 | Register access enabled |
| slv_addr | output | 7 | Slave address for the serial front end |
| edge_code | output | 4 | Edge-boost code |
| dc_code | output | 4 | DC-boost code |
| eq_code | output | 8 | Receive-equalization code |
| cfg_active | output | 1 | Holds the link state machine halted while 1 |

## Verification
The assertions assume that the strap and bus-line inputs are settled at the capture edge and that acc_off and acc_wr are never unknown once reset is released. The stimulus changes every input at the falling edge, well away from the capture edge. It keeps the write strobe low except during deliberate single-cycle writes. The one exception is the test that holds a write across reset release on purpose. The bench walks every combination of boost level, equalization level and bus-line pair. It then sweeps every offset, and the assertions track the translation tables and the freeze rules throughout.

// File: rtl/cfg_strap_pkg.sv
package cfg_strap_pkg;

   localparam int NSLOT = 4;

   typedef enum logic [1:0] {
      EQ_LOW  = 2'b00,
      EQ_MID  = 2'b01,
      EQ_HIGH = 2'b10,
      EQ_SPARE = 2'b11
   } eq_lvl_e;

   function automatic logic [3:0] edge_of(input logic [1:0] lvl);
      case (lvl)
         2'd0:    return 4'h0;
         2'd1:    return 4'h3;
         2'd2:    return 4'h6;
         default: return 4'hA;
      endcase
   endfunction

   function automatic logic [3:0] dc_of(input logic [1:0] lvl);
      case (lvl)
         2'd0:    return 4'h0;
         2'd3:    return 4'h6;
         default: return 4'h2;
      endcase
   endfunction

   function automatic logic [7:0] eq_of(input logic [1:0] lvl);
      case (eq_lvl_e'(lvl))
         EQ_LOW:  return 8'h00;
         EQ_HIGH: return 8'h66;
         default: return 8'h33;
      endcase
   endfunction

endpackage

// File: rtl/strap_latch.sv
module strap_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_lvl,
   input  logic sda_lvl,
   output logic cap_stb,
   output logic host_en
);
   logic armed_q;
   logic host_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         host_q  <= 1'b0;
      end else if (!armed_q) begin
         armed_q <= 1'b1;
         host_q  <= scl_lvl & sda_lvl;
      end
   end

   assign cap_stb = ~armed_q;
   assign host_en = host_q;
endmodule

// File: rtl/strap_xlate.sv
module strap_xlate
   import cfg_strap_pkg::*;
#(
   parameter int         DW        = 8,
   parameter logic [3:0] RSVD_EDGE = 4'h5,
   parameter logic [6:0] RSVD_CFG  = 7'h24,
   parameter logic [3:0] RSVD_DC   = 4'h9
) (
   input  logic [1:0]                  boost_lvl,
   input  logic [1:0]                  eq_lvl,
   output logic [NSLOT-1:0][DW-1:0]    init_vals
);
   always_comb begin
      init_vals[0] = {edge_of(boost_lvl), RSVD_EDGE};
      init_vals[1] = {RSVD_CFG, 1'b1};
      init_vals[2] = {RSVD_DC, dc_of(boost_lvl)};
      init_vals[3] = eq_of(eq_lvl);
   end
endmodule

// File: rtl/cfg_slots.sv
module cfg_slots
   import cfg_strap_pkg::*;
#(
   parameter int                          DW       = 8,
   parameter int                          AW       = 8,
   parameter bit                          RD_REG   = 1'b0,
   parameter logic [NSLOT-1:0][AW-1:0]    OFFS     = '0,
   parameter logic [NSLOT-1:0][DW-1:0]    RST_VALS = '0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cap_stb,
   input  logic                        host_en,
   input  logic [NSLOT-1:0][DW-1:0]    init_vals,
   input  logic [AW-1:0]               acc_off,
   input  logic [DW-1:0]               acc_wdata,
   input  logic                        acc_wr,
   output logic [NSLOT-1:0][DW-1:0]    slot_o,
   output logic [DW-1:0]               acc_rdata
);
   logic [DW-1:0]    mem [NSLOT];
   logic [NSLOT-1:0] hit;
   logic [DW-1:0]    rd_c;

   for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      assign hit[i] = (acc_off == OFFS[i]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem[i] <= RST_VALS[i];
         else if (cap_stb)
            mem[i] <= init_vals[i];
         else if (host_en && acc_wr && hit[i])
            mem[i] <= acc_wdata;
      end

      assign slot_o[i] = mem[i];
   end

   always_comb begin
      rd_c = '0;
      if (host_en) begin
         for (int k = 0; k < NSLOT; k++) begin
            if (hit[k]) rd_c = rd_c | mem[k];
         end
      end
   end

   if (RD_REG) begin : g_rd_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) acc_rdata <= '0;
         else        acc_rdata <= rd_c;
      end
   end else begin : g_rd_comb
      assign acc_rdata = rd_c;
   end
endmodule

// File: rtl/cfg_strap_bank.sv
module cfg_strap_bank
   import cfg_strap_pkg::*;
#(
   parameter int          DW        = 8,
   parameter int          AW        = 8,
   parameter logic [6:0]  SLV_ADDR  = 7'h2C,
   parameter logic [AW-1:0] OFF_EDGE = 'h01,
   parameter logic [AW-1:0] OFF_CFG  = 'h03,
   parameter logic [AW-1:0] OFF_DC   = 'h0E,
   parameter logic [AW-1:0] OFF_EQ   = 'h25,
   parameter logic [3:0]  RSVD_EDGE = 4'h5,
   parameter logic [6:0]  RSVD_CFG  = 7'h24,
   parameter logic [3:0]  RSVD_DC   = 4'h9,
   parameter bit          RD_REG    = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    boost_lvl,
   input  logic [1:0]    eq_lvl,
   input  logic          scl_lvl,
   input  logic          sda_lvl,
   input  logic [AW-1:0] acc_off,
   input  logic [DW-1:0] acc_wdata,
   input  logic          acc_wr,
   output logic [DW-1:0] acc_rdata,
   output logic          host_en,
   output logic [6:0]    slv_addr,
   output logic [3:0]    edge_code,
   output logic [3:0]    dc_code,
   output logic [DW-1:0] eq_code,
   output logic          cfg_active
);
   localparam logic [NSLOT-1:0][AW-1:0] OFFS = {OFF_EQ, OFF_DC, OFF_CFG, OFF_EDGE};
   localparam logic [NSLOT-1:0][DW-1:0] RST_VALS =
      {DW'(0), DW'(0), DW'(1), DW'(0)};

   if (DW != 8) begin : g_bad_dw
      $error("cfg_strap_bank: register width must be 8");
   end
   if (AW < 6) begin : g_bad_aw
      $error("cfg_strap_bank: offset width too small for the register map");
   end
   for (genvar i = 0; i < NSLOT; i++) begin : g_chk_i
      for (genvar j = i + 1; j < NSLOT; j++) begin : g_chk_j
         if (OFFS[i] == OFFS[j]) begin : g_dup
            $error("cfg_strap_bank: two registers share one offset");
         end
      end
   end

   logic                     cap_stb;
   logic [NSLOT-1:0][DW-1:0] init_vals;
   logic [NSLOT-1:0][DW-1:0] slot_q;
   logic                     sig_unused;

   strap_latch u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_lvl (scl_lvl),
      .sda_lvl (sda_lvl),
      .cap_stb (cap_stb),
      .host_en (host_en)
   );

   strap_xlate #(
      .DW        (DW),
      .RSVD_EDGE (RSVD_EDGE),
      .RSVD_CFG  (RSVD_CFG),
      .RSVD_DC   (RSVD_DC)
   ) u_xlate (
      .boost_lvl (boost_lvl),
      .eq_lvl    (eq_lvl),
      .init_vals (init_vals)
   );

   cfg_slots #(
      .DW       (DW),
      .AW       (AW),
      .RD_REG   (RD_REG),
      .OFFS     (OFFS),
      .RST_VALS (RST_VALS)
   ) u_slots (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_stb   (cap_stb),
      .host_en   (host_en),
      .init_vals (init_vals),
      .acc_off   (acc_off),
      .acc_wdata (acc_wdata),
      .acc_wr    (acc_wr),
      .slot_o    (slot_q),
      .acc_rdata (acc_rdata)
   );

   assign edge_code  = slot_q[0][7:4];
   assign cfg_active = slot_q[1][0];
   assign dc_code    = slot_q[2][3:0];
   assign eq_code    = slot_q[3];
   assign slv_addr   = SLV_ADDR;
   assign sig_unused = ^{slot_q[0][3:0], slot_q[1][7:1], slot_q[2][7:4]};
endmodule

// File: rtl/cfg_strap_chk.sv
module cfg_strap_chk #(
   parameter int            DW       = 8,
   parameter int            AW       = 8,
   parameter logic [AW-1:0] OFF_EDGE = 'h01,
   parameter logic [AW-1:0] OFF_CFG  = 'h03,
   parameter logic [AW-1:0] OFF_DC   = 'h0E,
   parameter logic [AW-1:0] OFF_EQ   = 'h25,
   parameter bit            RD_REG   = 1'b0
) (
   input logic          clk,
   input logic          rst_n,
   input logic [1:0]    boost_lvl,
   input logic [1:0]    eq_lvl,
   input logic          scl_lvl,
   input logic          sda_lvl,
   input logic [AW-1:0] acc_off,
   input logic [DW-1:0] acc_wdata,
   input logic          acc_wr,
   input logic [DW-1:0] acc_rdata,
   input logic          host_en,
   input logic [3:0]    edge_code,
   input logic [3:0]    dc_code,
   input logic [DW-1:0] eq_code,
   input logic          cfg_active
);
   logic seen_q;
   logic rsvd_off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q <= 1'b0;
      else        seen_q <= 1'b1;
   end

   assign rsvd_off = (acc_off != OFF_EDGE) && (acc_off != OFF_CFG) &&
                     (acc_off != OFF_DC) && (acc_off != OFF_EQ);

   function automatic logic [3:0] exp_edge(input logic [1:0] l);
      return (l == 2'd3) ? 4'hA : 4'(3 * l);
   endfunction
   function automatic logic [3:0] exp_dc(input logic [1:0] l);
      return (l == 2'd0) ? 4'h0 : ((l == 2'd3) ? 4'h6 : 4'h2);
   endfunction
   function automatic logic [7:0] exp_eq(input logic [1:0] l);
      return (l == 2'd0) ? 8'h00 : ((l == 2'd2) ? 8'h66 : 8'h33);
   endfunction

   AST_CAP_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_q |=> edge_code == exp_edge($past(boost_lvl))); // R3
   AST_CAP_DC: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_q |=> dc_code == exp_dc($past(boost_lvl))); // R4
   AST_CAP_EQ: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_q |=> eq_code == exp_eq($past(eq_lvl))); // R5
   AST_CAP_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_q |=> cfg_active); // R6
   AST_HOST_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_q |=> host_en == $past(scl_lvl & sda_lvl)); // R2
   AST_HOST_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      seen_q |=> $stable(host_en)); // R1
   AST_STRAP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      seen_q && !acc_wr |=> $stable({edge_code, dc_code, eq_code, cfg_active})); // R1
   AST_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      seen_q && !host_en |=> $stable({edge_code, dc_code, eq_code, cfg_active})); // R2
   AST_RSVD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      seen_q && acc_wr && rsvd_off |=> $stable({edge_code, dc_code, eq_code, cfg_active})); // R8
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (RD_REG == 1'b0) && rsvd_off |-> acc_rdata == '0); // R8
   AST_RD_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      (RD_REG == 1'b0) && !host_en |-> acc_rdata == '0); // R2
   AST_WR_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      seen_q && host_en && acc_wr && acc_off == OFF_EDGE |=>
         edge_code == $past(acc_wdata[7:4])); // R7
   AST_WR_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      seen_q && host_en && acc_wr && acc_off == OFF_CFG |=>
         cfg_active == $past(acc_wdata[0])); // R6
endmodule

bind cfg_strap_bank cfg_strap_chk #(
   .DW       (DW),
   .AW       (AW),
   .OFF_EDGE (OFF_EDGE),
   .OFF_CFG  (OFF_CFG),
   .OFF_DC   (OFF_DC),
   .OFF_EQ   (OFF_EQ),
   .RD_REG   (RD_REG)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .boost_lvl  (boost_lvl),
   .eq_lvl     (eq_lvl),
   .scl_lvl    (scl_lvl),
   .sda_lvl    (sda_lvl),
   .acc_off    (acc_off),
   .acc_wdata  (acc_wdata),
   .acc_wr     (acc_wr),
   .acc_rdata  (acc_rdata),
   .host_en    (host_en),
   .edge_code  (edge_code),
   .dc_code    (dc_code),
   .eq_code    (eq_code),
   .cfg_active (cfg_active)
);

// File: tb/sim_cfg_strap_bank.sv
`timescale 1ns/1ps
module sim_cfg_strap_bank;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] boost_lvl = 2'd0;
   logic [1:0] eq_lvl = 2'd0;
   logic       scl_lvl = 1'b0;
   logic       sda_lvl = 1'b0;
   logic [7:0] acc_off = 8'h00;
   logic [7:0] acc_wdata = 8'h00;
   logic       acc_wr = 1'b0;
   logic [7:0] acc_rdata;
   logic       host_en;
   logic [6:0] slv_addr;
   logic [3:0] edge_code;
   logic [3:0] dc_code;
   logic [7:0] eq_code;
   logic       cfg_active;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   cfg_strap_bank u0 (
      .clk(clk), .rst_n(rst_n), .boost_lvl(boost_lvl), .eq_lvl(eq_lvl),
      .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .acc_off(acc_off),
      .acc_wdata(acc_wdata), .acc_wr(acc_wr), .acc_rdata(acc_rdata),
      .host_en(host_en), .slv_addr(slv_addr), .edge_code(edge_code),
      .dc_code(dc_code), .eq_code(eq_code), .cfg_active(cfg_active)
   );

   function automatic logic [3:0] x_edge(input int l);
      return (l == 3) ? 4'hA : 4'(3 * l);
   endfunction
   function automatic logic [3:0] x_dc(input int l);
      return (l == 0) ? 4'h0 : ((l == 3) ? 4'h6 : 4'h2);
   endfunction
   function automatic logic [7:0] x_eq(input int l);
      return 8'(8'h33 * ((l == 0) ? 0 : ((l == 2) ? 2 : 1)));
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [7:0] off, output logic [7:0] val);
      acc_off = off;
      #1;
      val = acc_rdata;
   endtask

   task automatic wr(input logic [7:0] off, input logic [7:0] data);
      @(negedge clk);
      acc_off = off; acc_wdata = data; acc_wr = 1'b1;
      @(negedge clk);
      acc_wr = 1'b0;
   endtask

   // Reset with given straps; return at the falling edge after the capture edge.
   task automatic do_reset(input int b, input int e, input bit s, input bit d, input bit hold_wr);
      @(negedge clk);
      rst_n = 1'b0;
      boost_lvl = 2'(b); eq_lvl = 2'(e); scl_lvl = s; sda_lvl = d;
      acc_wr = hold_wr;
      repeat (2) @(negedge clk);
      chk("R11 edge in reset", 32'(edge_code), 0);
      chk("R11 dc in reset", 32'(dc_code), 0);
      chk("R11 eq in reset", 32'(eq_code), 0);
      chk("R11 cfg in reset", 32'(cfg_active), 1);
      chk("R11 host in reset", 32'(host_en), 0);
      rst_n = 1'b1;
      @(negedge clk);
      acc_wr = 1'b0;
   endtask

   initial begin
      logic [7:0] v;
      for (int b = 0; b < 4; b++) begin
         for (int e = 0; e < 4; e++) begin
            for (int m = 0; m < 4; m++) begin
               bit host;
               host = (m == 3);
               do_reset(b, e, m[1], m[0], 1'b0);
               chk("R3 edge capture", 32'(edge_code), 32'(x_edge(b)));
               chk("R4 dc capture", 32'(dc_code), 32'(x_dc(b)));
               chk("R5 eq capture", 32'(eq_code), 32'(x_eq(e)));
               chk("R6 cfg after capture", 32'(cfg_active), 1);
               chk("R2 host enable", 32'(host_en), 32'(host));
               chk("R10 slave address", 32'(slv_addr), 32'h2C);
               if (host) begin
                  rd(8'h01, v); chk("R3 read 0x01", 32'(v), 32'({x_edge(b), 4'h5}));
                  rd(8'h03, v); chk("R6 read 0x03", 32'(v), 32'({7'h24, 1'b1}));
                  rd(8'h0E, v); chk("R4 read 0x0E", 32'(v), 32'({4'h9, x_dc(b)}));
                  rd(8'h25, v); chk("R5 read 0x25", 32'(v), 32'(x_eq(e)));
               end else begin
                  rd(8'h01, v); chk("R2 read closed", 32'(v), 0);
                  wr(8'h01, 8'hFF);
                  wr(8'h03, 8'h00);
                  chk("R2 write closed edge", 32'(edge_code), 32'(x_edge(b)));
                  chk("R2 write closed cfg", 32'(cfg_active), 1);
               end
               boost_lvl = ~boost_lvl; eq_lvl = ~eq_lvl;
               scl_lvl = ~scl_lvl; sda_lvl = ~sda_lvl;
               repeat (3) @(negedge clk);
               chk("R1 edge frozen", 32'(edge_code), 32'(x_edge(b)));
               chk("R1 dc frozen", 32'(dc_code), 32'(x_dc(b)));
               chk("R1 eq frozen", 32'(eq_code), 32'(x_eq(e)));
               chk("R1 host frozen", 32'(host_en), 32'(host));
            end
         end
      end

      // Writes in host mode
      do_reset(1, 2, 1'b1, 1'b1, 1'b0);
      wr(8'h01, 8'hC3);
      chk("R7 edge write", 32'(edge_code), 32'hC);
      rd(8'h01, v); chk("R7 read 0x01", 32'(v), 32'hC3);
      wr(8'h0E, 8'h7B);
      chk("R7 dc write", 32'(dc_code), 32'hB);
      rd(8'h0E, v); chk("R7 read 0x0E", 32'(v), 32'h7B);
      wr(8'h25, 8'hFF);
      chk("R7 eq write", 32'(eq_code), 32'hFF);
      wr(8'h03, 8'h00);
      chk("R6 cfg cleared", 32'(cfg_active), 0);
      rd(8'h03, v); chk("R7 read 0x03", 32'(v), 0);
      wr(8'h03, 8'hA5);
      chk("R6 cfg set", 32'(cfg_active), 1);

      // Reserved offsets
      for (int o = 0; o < 256; o++) begin
         if (o != 8'h01 && o != 8'h03 && o != 8'h0E && o != 8'h25) begin
            wr(8'(o), 8'hFF);
            rd(8'(o), v);
            chk("R8 reserved reads zero", 32'(v), 0);
         end
      end
      rd(8'h01, v); chk("R8 0x01 untouched", 32'(v), 32'hC3);
      rd(8'h03, v); chk("R8 0x03 untouched", 32'(v), 32'hA5);
      rd(8'h0E, v); chk("R8 0x0E untouched", 32'(v), 32'h7B);
      rd(8'h25, v); chk("R8 0x25 untouched", 32'(v), 32'hFF);

      // Write coinciding with capture
      acc_off = 8'h01; acc_wdata = 8'hFF;
      do_reset(2, 1, 1'b1, 1'b1, 1'b1);
      chk("R9 edge kept", 32'(edge_code), 32'(x_edge(2)));
      acc_off = 8'h03; acc_wdata = 8'h00;
      do_reset(0, 0, 1'b1, 1'b1, 1'b1);
      chk("R9 cfg kept", 32'(cfg_active), 1);
      rd(8'h03, v); chk("R9 read 0x03", 32'(v), 32'({7'h24, 1'b1}));

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule